// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link into a small bank of byte-wide registers. The master drives a serial clock, a frame strobe and one data line that can be turned around for reads. While the strobe is high, the block takes one bit on each rising serial-clock edge. A write frame carries the value byte first and the target address byte second. The write does not reach the register when the sixteenth bit is taken. It reaches the register only when the strobe falls, and only if the frame had exactly sixteen clock edges.

For a read, the master shifts in only the address. The block then returns the addressed register on the falling serial-clock edges, and it enables its output driver only for as long as it is returning data. All three serial lines, and a read-select line, are synchronised into the system clock, so the serial clock must run well below the system clock. An active-low asynchronous reset returns every register to its power-up value and abandons any frame in flight.

Top module: `ser3w_regport`

## Requirements
- R1: During and after reset (rst_n low), register i reads (0xA0 + 0x11*i) mod 256 on regs_q[8*i+7:8*i], and sdio_oe is 0.
- R2: With ser_rd low at the strobe's rise, the 16 bits sampled on ser_clk rising edges form the frame. The first 8 bits are the data byte, MSB first. The last 8 bits are the address byte, MSB first. The data byte is written to the register at that address.
- R3: A complete write frame leaves the register unchanged for as long as ser_stb stays high. The new value appears only after ser_stb falls.
- R4: A write frame with any number of rising ser_clk edges other than 16 (for example 15 or 17) changes no register.
- R5: A write to an address at or above the register count (8) changes no register.
- R6: With ser_rd high at the strobe's rise, the first 8 rising edges carry the address, MSB first. From the next falling ser_clk edge, sdio_oe is 1 and sdio_out presents the addressed register MSB first, advancing one bit per falling edge.
- R7: sdio_oe is 0 throughout write frames and is 0 again after ser_stb falls. A read frame changes no register.
- R8: Asserting rst_n in the middle of a frame restores all registers to their defaults. The remainder of that frame, completed after reset, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the master |
| ser_stb | input | 1 | Frame strobe, high while a frame is in progress |
| ser_rd | input | 1 | Read select, captured when the strobe rises |
| sdio_in | input | 1 | Serial data from the master |
| sdio_out | output | 1 | Serial read data toward the master |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| regs_q | output | 64 | All register contents, register i at bits 8*i+7:8*i |

## Verification
A miscounted bit counter or a badly framed shift register shows at regs_q within a few system cycles of the strobe falling. It appears as a wrong byte, a wrong register, or an update where there should be none. A write that is committed too early shows on regs_q while the strobe is still high, before the fall. A wrong read mode or a misloaded output shifter shows on sdio_out and sdio_oe at the first falling serial edge after the address, which is within one serial bit time. A driver that stays enabled shows on sdio_oe a few system cycles after the strobe drops.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_kind_e;

   // power-up value of register idx
   function automatic logic [31:0] power_up_value(input int idx, input int base, input int step);
      return 32'(base + idx * step);
   endfunction

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ser3w_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= async_in;
         end else begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ser3w_engine.sv
module ser3w_engine
   import ser3w_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk_s,
   input  logic          stb_s,
   input  logic          rd_s,
   input  logic          din_s,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] acc_addr,
   output logic [DW-1:0] wr_data,
   output logic          wr_en,
   output logic          dout,
   output logic          oe
);

   localparam int FW    = DW + AW;
   localparam int CNT_W = $clog2(FW + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
   localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(AW);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);

   logic            sclk_d, stb_d;
   logic            clk_rise, clk_fall, stb_rise, stb_fall;
   logic [CNT_W-1:0] bit_cnt;
   logic [FW-1:0]   shreg;
   logic [DW-1:0]   out_sr;
   logic            loaded;
   xfer_kind_e      kind;

   assign clk_rise = sclk_s & ~sclk_d;
   assign clk_fall = ~sclk_s & sclk_d;
   assign stb_rise = stb_s & ~stb_d;
   assign stb_fall = ~stb_s & stb_d;

   assign acc_addr = shreg[AW-1:0];
   assign wr_data  = shreg[FW-1:AW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         stb_d   <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         out_sr  <= '0;
         loaded  <= 1'b0;
         kind    <= XFER_WRITE;
         wr_en   <= 1'b0;
         dout    <= 1'b0;
         oe      <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         stb_d  <= stb_s;
         wr_en  <= 1'b0;
         if (stb_rise) begin
            bit_cnt <= '0;
            kind    <= rd_s ? XFER_READ : XFER_WRITE;
            loaded  <= 1'b0;
            oe      <= 1'b0;
         end else if (stb_fall) begin
            oe     <= 1'b0;
            loaded <= 1'b0;
            if (kind == XFER_WRITE && bit_cnt == CNT_FULL) begin
               wr_en <= 1'b1;
            end
         end else if (stb_s) begin
            if (clk_rise) begin
               if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
               if (kind == XFER_WRITE || bit_cnt < CNT_ADDR) begin
                  shreg <= {shreg[FW-2:0], din_s};
               end
            end
            if (clk_fall && kind == XFER_READ && bit_cnt >= CNT_ADDR) begin
               oe <= 1'b1;
               if (!loaded) begin
                  loaded <= 1'b1;
                  dout   <= rd_data[DW-1];
                  out_sr <= rd_data << 1;
               end else begin
                  dout   <= out_sr[DW-1];
                  out_sr <= out_sr << 1;
               end
            end
         end
      end
   end

   // R4: a commit only follows a frame of exactly FW rising edges
   a_r4_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(bit_cnt) == CNT_FULL);

   // R6: driver only turns on in a read after the address byte
   a_r6_oe_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> (kind == XFER_READ && $past(bit_cnt) >= CNT_ADDR));

   // R7: strobe fall releases the data pin
   a_r7_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
      stb_fall |=> !oe);

   // R7: no driving during writes
   a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == XFER_WRITE && !stb_rise) |=> !oe);

endmodule

// File: rtl/ser3w_regbank.sv
module ser3w_regbank
   import ser3w_pkg::*;
#(
   parameter int NREG       = 8,
   parameter int DW         = 8,
   parameter int AW         = 8,
   parameter int RESET_BASE = 'hA0,
   parameter int RESET_STEP = 'h11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wr_data,
   output logic [DW-1:0]      rd_data,
   output logic [NREG*DW-1:0] q_flat
);

   if (NREG < 1 || NREG > (1 << AW)) begin : g_bad_nreg
      $error("ser3w_regbank: NREG must be between 1 and 2**AW");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DW-1:0] INIT = DW'(power_up_value(i, RESET_BASE, RESET_STEP));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_flat[i*DW +: DW] <= INIT;
         end else if (wr_en && addr == AW'(i)) begin
            q_flat[i*DW +: DW] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (addr == AW'(i)) rd_data = q_flat[i*DW +: DW];
      end
   end

   // R3: contents move only on a commit pulse from the engine
   a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> q_flat == $past(q_flat));

   // R5: out-of-range commits touch nothing
   a_r5_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) >= NREG) |=> q_flat == $past(q_flat));

endmodule

// File: rtl/ser3w_regport.sv
module ser3w_regport #(
   parameter int NREG        = 8,
   parameter int DW          = 8,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RESET_BASE  = 'hA0,
   parameter int RESET_STEP  = 'h11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_stb,
   input  logic               ser_rd,
   input  logic               sdio_in,
   output logic               sdio_out,
   output logic               sdio_oe,
   output logic [NREG*DW-1:0] regs_q
);

   localparam int NSYNC = 4;

   if (DW < 2 || AW < 1) begin : g_bad_width
      $error("ser3w_regport: DW must be >= 2 and AW >= 1");
   end

   logic [NSYNC-1:0] pins_s;
   logic [AW-1:0]    acc_addr;
   logic [DW-1:0]    wr_data, rd_data;
   logic             wr_en;

   ser3w_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({ser_clk, ser_stb, ser_rd, sdio_in}),
      .sync_out (pins_s)
   );

   ser3w_engine #(.DW(DW), .AW(AW)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (pins_s[3]),
      .stb_s    (pins_s[2]),
      .rd_s     (pins_s[1]),
      .din_s    (pins_s[0]),
      .rd_data  (rd_data),
      .acc_addr (acc_addr),
      .wr_data  (wr_data),
      .wr_en    (wr_en),
      .dout     (sdio_out),
      .oe       (sdio_oe)
   );

   ser3w_regbank #(
      .NREG(NREG), .DW(DW), .AW(AW),
      .RESET_BASE(RESET_BASE), .RESET_STEP(RESET_STEP)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (acc_addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .q_flat  (regs_q)
   );

endmodule

// File: tb/ser3w_regport_test.sv
module ser3w_regport_test;

   localparam int HP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_stb = 1'b0, ser_rd = 1'b0, sdio_in = 1'b0;
   logic        sdio_out, sdio_oe;
   logic [63:0] regs_q;

   int          n_chk = 0, n_bad = 0;
   logic [7:0]  exp_r [8];

   always #10 clk = ~clk;

   ser3w_regport uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_stb(ser_stb),
      .ser_rd(ser_rd), .sdio_in(sdio_in), .sdio_out(sdio_out),
      .sdio_oe(sdio_oe), .regs_q(regs_q)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_defaults();
      for (int i = 0; i < 8; i++) exp_r[i] = 8'(8'hA0 + 8'h11 * i);
   endtask

   task automatic check_regs(input string req);
      for (int i = 0; i < 8; i++) begin
         n_chk++;
         if (regs_q[i*8 +: 8] !== exp_r[i]) begin
            n_bad++;
            $display("FAIL %s reg%0d actual %h expected %h", req, i, regs_q[i*8 +: 8], exp_r[i]);
         end
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual %b expected %b", req, act, expv);
      end
   endtask

   task automatic shift_out_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdio_in = v[i];
         wait_n(HP);
         ser_clk = 1'b1;
         wait_n(HP);
         ser_clk = 1'b0;
      end
   endtask

   task automatic write_frame(input logic [31:0] bits, input int n, input string req);
      ser_rd = 1'b0; ser_stb = 1'b1;
      wait_n(HP);
      shift_out_bits(bits, n);
      wait_n(HP);
      check_bit({req, " oe low in write"}, sdio_oe, 1'b0);
      ser_stb = 1'b0;
      wait_n(12);
   endtask

   task automatic read_frame(input logic [7:0] addr, input logic [7:0] expv, input string req);
      ser_rd = 1'b1; ser_stb = 1'b1;
      wait_n(HP);
      shift_out_bits({24'd0, addr}, 8);
      sdio_in = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         wait_n(HP);
         check_bit({req, " oe during read"}, sdio_oe, 1'b1);
         check_bit({req, " read bit"}, sdio_out, expv[i]);
         ser_clk = 1'b1;
         wait_n(HP);
         ser_clk = 1'b0;
      end
      wait_n(HP);
      ser_stb = 1'b0; ser_rd = 1'b0;
      wait_n(12);
      check_bit("R7 oe released after strobe", sdio_oe, 1'b0);
   endtask

   // R1
   task automatic t_reset();
      set_defaults();
      wait_n(3);
      check_regs("R1 in reset");
      check_bit("R1 oe in reset", sdio_oe, 1'b0);
      rst_n = 1'b1;
      wait_n(5);
      check_regs("R1 after reset");
   endtask

   // R2
   task automatic t_writes();
      write_frame({16'd0, 8'h5A, 8'h00}, 16, "R2");
      exp_r[0] = 8'h5A; check_regs("R2 write addr0");
      write_frame({16'd0, 8'hC3, 8'h07}, 16, "R2");
      exp_r[7] = 8'hC3; check_regs("R2 write addr7");
      write_frame({16'd0, 8'h81, 8'h03}, 16, "R2");
      exp_r[3] = 8'h81; check_regs("R2 write addr3");
   endtask

   // R3
   task automatic t_commit_on_fall();
      ser_rd = 1'b0; ser_stb = 1'b1;
      wait_n(HP);
      shift_out_bits({16'd0, 8'h3C, 8'h05}, 16);
      wait_n(30);
      check_regs("R3 unchanged before strobe fall");
      ser_stb = 1'b0;
      wait_n(12);
      exp_r[5] = 8'h3C; check_regs("R3 committed after fall");
   endtask

   // R4
   task automatic t_bad_count();
      write_frame({17'd0, 8'h77, 7'h01}, 15, "R4");
      check_regs("R4 15-bit frame dropped");
      write_frame({7'd0, 8'h66, 8'h02, 1'b0, 8'h00}, 17, "R4");
      check_regs("R4 17-bit frame dropped");
   endtask

   // R5
   task automatic t_range();
      write_frame({16'd0, 8'h11, 8'h08}, 16, "R5");
      check_regs("R5 addr 0x08 ignored");
      write_frame({16'd0, 8'h22, 8'h80}, 16, "R5");
      check_regs("R5 addr 0x80 ignored");
   endtask

   // R6, R7
   task automatic t_reads();
      read_frame(8'h07, exp_r[7], "R6 addr7");
      read_frame(8'h02, exp_r[2], "R6 addr2 default");
      read_frame(8'h00, exp_r[0], "R6 addr0");
      check_regs("R7 reads modify nothing");
   endtask

   // R8
   task automatic t_midframe_reset();
      ser_rd = 1'b0; ser_stb = 1'b1;
      wait_n(HP);
      shift_out_bits({22'd0, 10'h2A5}, 10);
      rst_n = 1'b0;
      wait_n(3);
      set_defaults();
      check_regs("R8 defaults during reset");
      rst_n = 1'b1;
      wait_n(4);
      shift_out_bits({26'd0, 6'h01}, 6);
      wait_n(HP);
      ser_stb = 1'b0;
      wait_n(12);
      check_regs("R8 tail of aborted frame ignored");
   endtask

   initial begin
      t_reset();
      t_writes();
      t_commit_on_fall();
      t_bad_count();
      t_range();
      t_reads();
      t_midframe_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule